// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Selectable Write Policy and Flush

This block sits between a processor request port and a line-wide memory port. It keeps 16 lines of four 32-bit words, direct mapped, with one tag entry per line that carries a valid bit, a dirty bit and the tag. Reads that hit return in the cycle after acceptance. Misses fetch the whole line from memory. If the line being replaced holds modified data, that data is first written back to memory at the old tag's address.

The write policy is picked at run time by a mode input. In write-back mode, writes land only in the cache and mark the line dirty. A write miss first fetches the line, then merges the write into it. In write-through mode, every write also sends the merged line to memory. The dirty bit is never set in this mode. A write miss in this mode does not allocate a line: it reads the memory line, merges the bytes, and writes the line back. Changing the mode leaves existing dirty lines untouched.

A flush request walks the indices from 0 up to 15. It writes out each line that is both valid and dirty, clears that line's dirty bit, and raises a single-cycle done pulse at the end. The processor port is held off until the flush has finished.

Top module: `wb_cache`

## Requirements
- R1: After reset, cpu_ready_o is 1, mem_valid_o is 0, flush_done_o is 0, and all lines are invalid, so the first access to any address misses.
- R2: A read miss fetches the line with one memory read at the line-aligned address and returns the addressed word. A read hit returns the word one cycle after acceptance, with no memory transfer.
- R3: In write-back mode (wt_mode_i=0), a write hit updates only the cached word and starts no memory transfer. Byte lane i (bits 8i+7:8i) is taken from cpu_wdata_i only when cpu_be_i[i] is 1, and the line's dirty bit is set.
- R4: A miss whose victim line is valid and dirty first writes the victim's data to the address {old tag, index, 4'b0000}. Only after that write does it read the new line.
- R5: A miss whose victim is clean or invalid replaces the line with no memory write.
- R6: In write-through mode (wt_mode_i=1), a write hit updates the cached word and writes the merged line to memory before responding. The dirty bit is not set, so evicting that line later causes no write.
- R7: In write-through mode, a write miss reads the memory line, merges the enabled bytes, and writes the line back. The line is not allocated, so a later read of it misses.
- R8: In write-back mode, a write miss fetches the line, merges the enabled bytes, and installs it as dirty, with no memory write.
- R9: Switching wt_mode_i from 0 to 1 does not clean the cache. Lines that are already dirty are still written out by a later flush or eviction.
- R10: flush_i, taken while idle, writes every valid and dirty line in ascending index order and clears each dirty bit. It then pulses flush_done_o high for exactly one cycle, and cpu_ready_o stays low until then. A flush with no dirty lines writes nothing and still pulses done.
- R11: A memory transfer completes in the cycle where mem_valid_o and mem_ready_i are both 1. Until then, mem_valid_o, mem_we_o, mem_addr_o and mem_wdata_o hold steady, and the low 4 address bits are 0.
- R12: The byte address is split as follows: bits 1:0 are the byte offset, bits 3:2 the word in the line, bits 7:4 the index and bits 31:8 the tag. Addresses that differ only in the tag map to the same line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wt_mode_i | input | 1 | 1 = write-through, 0 = write-back |
| flush_i | input | 1 | Request to write out all dirty lines |
| flush_done_o | output | 1 | One-cycle pulse when a flush ends |
| cpu_valid_i | input | 1 | Processor request valid |
| cpu_ready_o | output | 1 | Request accepted when high together with valid |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 32 | Byte address |
| cpu_wdata_i | input | 32 | Write data |
| cpu_be_i | input | 4 | Byte enables |
| cpu_rvalid_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | 32 | Read data, valid with cpu_rvalid_o |
| mem_valid_o | output | 1 | Memory transfer request |
| mem_ready_i | input | 1 | Memory accepts the transfer |
| mem_we_o | output | 1 | 1 = line write, 0 = line read |
| mem_addr_o | output | 32 | Line-aligned address |
| mem_wdata_o | output | 128 | Line write data |
| mem_rdata_i | input | 128 | Line read data, valid with the read handshake |

## Verification
Each corner case is set up deliberately and checked by counting memory reads and writes and by inspecting the backing memory. The corner cases are a dirty victim, a clean victim, write hits and misses under both policies, partial byte enables, and a mode change that must leave dirty lines alone. If a design wrote through in write-back mode, or never set the dirty bit, the write counts would be off or the evicted data would be missing from memory. If a design allocated on a write-through miss, the follow-up read would hit when it should miss. The flush runs are checked for ascending write order, for a processor port held off until done, and for a second flush that writes nothing. A design that forgot to clear dirty bits, or that skipped lines, fails these checks.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVICT,
    ST_FILL,
    ST_WTHRU,
    ST_FSCAN,
    ST_FWR
  } wbc_state_e;
endpackage

// File: rtl/wbc_tag_store.sv
module wbc_tag_store #(
  parameter int LINES = 16,
  parameter int TAG_W = 24,
  localparam int IDX_W = $clog2(LINES),
  localparam int ENT_W = TAG_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_valid_o,
  output logic             rd_dirty_o,
  output logic [TAG_W-1:0] rd_tag_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_valid_i,
  input  logic             wr_dirty_i,
  input  logic [TAG_W-1:0] wr_tag_i
);
  // entry = {valid, dirty, tag}; dirty rides in the tag word
  logic [ENT_W-1:0] ent_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) ent_q[i] <= '0;
    end else if (wr_en_i) begin
      ent_q[wr_idx_i] <= {wr_valid_i, wr_dirty_i, wr_tag_i};
    end
  end

  assign rd_valid_o = ent_q[rd_idx_i][ENT_W-1];
  assign rd_dirty_o = ent_q[rd_idx_i][ENT_W-2];
  assign rd_tag_o   = ent_q[rd_idx_i][TAG_W-1:0];

  AST_DIRTY_IMPLIES_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_dirty_i |-> wr_valid_i); // R3
endmodule

// File: rtl/wbc_data_store.sv
module wbc_data_store #(
  parameter int LINES  = 16,
  parameter int LINE_W = 128,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [LINE_W-1:0] rd_line_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [LINE_W-1:0] wr_line_i
);
  logic [LINE_W-1:0] mem_q [LINES];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_line_i;
  end

  assign rd_line_o = mem_q[rd_idx_i];
endmodule

// File: rtl/wbc_merge.sv
module wbc_merge #(
  parameter int WORDS  = 4,
  parameter int WORD_W = 32,
  localparam int BYTES  = WORD_W / 8,
  localparam int WOFF_W = $clog2(WORDS),
  localparam int LINE_W = WORDS * WORD_W
) (
  input  logic [LINE_W-1:0] line_i,
  input  logic [WOFF_W-1:0] sel_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [BYTES-1:0]  be_i,
  output logic [LINE_W-1:0] line_o
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
      assign line_o[w*WORD_W + b*8 +: 8] =
        (sel_i == WOFF_W'(w) && be_i[b]) ? wdata_i[b*8 +: 8]
                                         : line_i[w*WORD_W + b*8 +: 8];
    end
  end
endmodule

// File: rtl/wb_cache.sv
module wb_cache
  import wbc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int LINES  = 16,
  localparam int BYTES  = WORD_W / 8,
  localparam int OFF_W  = $clog2(BYTES),
  localparam int WOFF_W = $clog2(WORDS),
  localparam int IDX_W  = $clog2(LINES),
  localparam int LOW_W  = OFF_W + WOFF_W,
  localparam int TAG_W  = ADDR_W - IDX_W - LOW_W,
  localparam int LINE_W = WORDS * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wt_mode_i,
  input  logic              flush_i,
  output logic              flush_done_o,
  input  logic              cpu_valid_i,
  output logic              cpu_ready_o,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [WORD_W-1:0] cpu_wdata_i,
  input  logic [BYTES-1:0]  cpu_be_i,
  output logic              cpu_rvalid_o,
  output logic [WORD_W-1:0] cpu_rdata_o,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [LINE_W-1:0] mem_wdata_o,
  input  logic [LINE_W-1:0] mem_rdata_i
);
  wbc_state_e state_q;

  logic [TAG_W-1:0]  req_tag_q;
  logic [IDX_W-1:0]  req_idx_q, scan_q;
  logic [WOFF_W-1:0] req_word_q;
  logic              req_we_q, req_wt_q;
  logic [WORD_W-1:0] req_wdata_q;
  logic [BYTES-1:0]  req_be_q;
  logic [LINE_W-1:0] linebuf_q;
  logic              rvalid_q, fdone_q;
  logic [WORD_W-1:0] rdata_q;

  logic [TAG_W-1:0]  cpu_tag;
  logic [IDX_W-1:0]  cpu_idx, lk_idx;
  logic [WOFF_W-1:0] cpu_word, cur_word;
  logic              t_valid, t_dirty, hit, idle, mem_fire, scan_last;
  logic [TAG_W-1:0]  t_tag;
  logic [LINE_W-1:0] d_line, merge_base, merged;
  logic [WORD_W-1:0] cur_wdata, rsel;
  logic [BYTES-1:0]  cur_be;
  logic              tw_en, tw_valid, tw_dirty, dw_en;
  logic [IDX_W-1:0]  tw_idx, dw_idx;
  logic [TAG_W-1:0]  tw_tag;
  logic [LINE_W-1:0] dw_line;
  logic              unused_addr_bits;

  assign cpu_tag  = cpu_addr_i[ADDR_W-1 -: TAG_W];
  assign cpu_idx  = cpu_addr_i[LOW_W +: IDX_W];
  assign cpu_word = cpu_addr_i[OFF_W +: WOFF_W];
  assign unused_addr_bits = ^cpu_addr_i[OFF_W-1:0];

  assign idle      = (state_q == ST_IDLE);
  assign lk_idx    = idle ? cpu_idx :
                     (state_q == ST_FSCAN || state_q == ST_FWR) ? scan_q : req_idx_q;
  assign hit       = t_valid && (t_tag == cpu_tag);
  assign scan_last = (scan_q == IDX_W'(LINES - 1));

  assign cur_word   = idle ? cpu_word    : req_word_q;
  assign cur_wdata  = idle ? cpu_wdata_i : req_wdata_q;
  assign cur_be     = idle ? cpu_be_i    : req_be_q;
  assign merge_base = idle ? d_line      : mem_rdata_i;
  assign rsel       = merge_base[cur_word*WORD_W +: WORD_W];

  wbc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) i_tags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (lk_idx),
    .rd_valid_o (t_valid),
    .rd_dirty_o (t_dirty),
    .rd_tag_o   (t_tag),
    .wr_en_i    (tw_en),
    .wr_idx_i   (tw_idx),
    .wr_valid_i (tw_valid),
    .wr_dirty_i (tw_dirty),
    .wr_tag_i   (tw_tag)
  );

  wbc_data_store #(.LINES(LINES), .LINE_W(LINE_W)) i_data (
    .clk_i     (clk_i),
    .rd_idx_i  (lk_idx),
    .rd_line_o (d_line),
    .wr_en_i   (dw_en),
    .wr_idx_i  (dw_idx),
    .wr_line_i (dw_line)
  );

  wbc_merge #(.WORDS(WORDS), .WORD_W(WORD_W)) i_merge (
    .line_i  (merge_base),
    .sel_i   (cur_word),
    .wdata_i (cur_wdata),
    .be_i    (cur_be),
    .line_o  (merged)
  );

  // memory port
  always_comb begin
    mem_valid_o = 1'b0;
    mem_we_o    = 1'b1;
    mem_addr_o  = '0;
    mem_wdata_o = d_line;
    unique case (state_q)
      ST_EVICT: begin
        mem_valid_o = 1'b1;
        mem_addr_o  = {t_tag, req_idx_q, {LOW_W{1'b0}}};
      end
      ST_FILL: begin
        mem_valid_o = 1'b1;
        mem_we_o    = 1'b0;
        mem_addr_o  = {req_tag_q, req_idx_q, {LOW_W{1'b0}}};
      end
      ST_WTHRU: begin
        mem_valid_o = 1'b1;
        mem_addr_o  = {req_tag_q, req_idx_q, {LOW_W{1'b0}}};
        mem_wdata_o = linebuf_q;
      end
      ST_FWR: begin
        mem_valid_o = 1'b1;
        mem_addr_o  = {t_tag, scan_q, {LOW_W{1'b0}}};
      end
      default: ;
    endcase
  end
  assign mem_fire = mem_valid_o && mem_ready_i;

  // array write ports
  always_comb begin
    tw_en = 1'b0; tw_idx = lk_idx; tw_valid = 1'b1; tw_dirty = 1'b0; tw_tag = t_tag;
    dw_en = 1'b0; dw_idx = lk_idx; dw_line = merged;
    unique case (state_q)
      ST_IDLE: if (cpu_valid_i && !flush_i && hit && cpu_we_i) begin
        dw_en = 1'b1;
        if (!wt_mode_i) begin
          tw_en    = 1'b1;
          tw_dirty = 1'b1;
        end
      end
      ST_FILL: if (mem_fire && !(req_we_q && req_wt_q)) begin
        tw_en    = 1'b1;
        tw_dirty = req_we_q;
        tw_tag   = req_tag_q;
        dw_en    = 1'b1;
        dw_line  = req_we_q ? merged : mem_rdata_i;
      end
      ST_FWR: if (mem_fire) begin
        tw_en = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      req_tag_q   <= '0;
      req_idx_q   <= '0;
      req_word_q  <= '0;
      req_we_q    <= 1'b0;
      req_wt_q    <= 1'b0;
      req_wdata_q <= '0;
      req_be_q    <= '0;
      scan_q      <= '0;
      linebuf_q   <= '0;
      rvalid_q    <= 1'b0;
      rdata_q     <= '0;
      fdone_q     <= 1'b0;
    end else begin
      rvalid_q <= 1'b0;
      fdone_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (flush_i) begin
            scan_q  <= '0;
            state_q <= ST_FSCAN;
          end else if (cpu_valid_i) begin
            req_tag_q   <= cpu_tag;
            req_idx_q   <= cpu_idx;
            req_word_q  <= cpu_word;
            req_we_q    <= cpu_we_i;
            req_wt_q    <= wt_mode_i;
            req_wdata_q <= cpu_wdata_i;
            req_be_q    <= cpu_be_i;
            if (hit) begin
              if (cpu_we_i && wt_mode_i) begin
                linebuf_q <= merged;
                state_q   <= ST_WTHRU;
              end else begin
                rvalid_q <= 1'b1;
                rdata_q  <= rsel;
              end
            end else if (cpu_we_i && wt_mode_i) begin
              state_q <= ST_FILL;  // read-modify-write, no allocation
            end else if (t_valid && t_dirty) begin
              state_q <= ST_EVICT;
            end else begin
              state_q <= ST_FILL;
            end
          end
        end
        ST_EVICT: if (mem_fire) state_q <= ST_FILL;
        ST_FILL: if (mem_fire) begin
          if (req_we_q && req_wt_q) begin
            linebuf_q <= merged;
            state_q   <= ST_WTHRU;
          end else begin
            rvalid_q <= 1'b1;
            rdata_q  <= rsel;
            state_q  <= ST_IDLE;
          end
        end
        ST_WTHRU: if (mem_fire) begin
          rvalid_q <= 1'b1;
          rdata_q  <= req_wdata_q;
          state_q  <= ST_IDLE;
        end
        ST_FSCAN: begin
          if (t_valid && t_dirty) begin
            state_q <= ST_FWR;
          end else if (scan_last) begin
            fdone_q <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            scan_q <= scan_q + 1'b1;
          end
        end
        ST_FWR: if (mem_fire) begin
          if (scan_last) begin
            fdone_q <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            scan_q  <= scan_q + 1'b1;
            state_q <= ST_FSCAN;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_ready_o  = idle && !flush_i;
  assign cpu_rvalid_o = rvalid_q;
  assign cpu_rdata_o  = rdata_q;
  assign flush_done_o = fdone_q;

  AST_FLUSH_BLOCKS_CPU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FSCAN || state_q == ST_FWR) |-> !cpu_ready_o); // R10
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_done_o |=> !flush_done_o); // R10
  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_we_o)
      && $stable(mem_addr_o) && $stable(mem_wdata_o)); // R11
  AST_EVICT_THEN_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EVICT) && mem_fire |=> mem_valid_o && !mem_we_o); // R4
  AST_WT_NEVER_DIRTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tw_en && tw_dirty |-> !(idle ? wt_mode_i : req_wt_q)); // R6
  AST_WB_HIT_NO_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_valid_i && cpu_ready_o && hit && !wt_mode_i |=> !mem_valid_o); // R3
endmodule

// File: tb/test_wb_cache.sv
module test_wb_cache;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wt_mode = 1'b0, flush = 1'b0, flush_done;
  logic         cpu_valid = 1'b0, cpu_ready, cpu_we = 1'b0, cpu_rvalid;
  logic [31:0]  cpu_addr = '0, cpu_wdata = '0, cpu_rdata;
  logic [3:0]   cpu_be = '0;
  logic         mem_valid, mem_ready, mem_we;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata, mem_rdata;

  int n_chk = 0, n_fail = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [31:0]  wr_log [64];
  logic [127:0] bmem [256];
  logic [1:0]   rdy_cnt = '0;

  always #5 clk = ~clk;

  wb_cache i_wb_cache (
    .clk_i(clk), .rst_ni(rst_n), .wt_mode_i(wt_mode), .flush_i(flush),
    .flush_done_o(flush_done), .cpu_valid_i(cpu_valid), .cpu_ready_o(cpu_ready),
    .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_be_i(cpu_be), .cpu_rvalid_o(cpu_rvalid), .cpu_rdata_o(cpu_rdata),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  // backing memory: 256 lines selected by address bits 11:4
  assign mem_ready = (rdy_cnt != 2'd3);
  assign mem_rdata = bmem[mem_addr[11:4]];
  always_ff @(posedge clk) begin
    rdy_cnt <= rdy_cnt + 2'd1;
    if (mem_valid && mem_ready) begin
      if (mem_we) begin
        bmem[mem_addr[11:4]] <= mem_wdata;
        wr_log[wr_cnt % 64]  <= mem_addr;
        wr_cnt <= wr_cnt + 1;
      end else begin
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  function automatic logic [31:0] pat(int ln, int w);
    return 32'h5000_0000 | (ln << 8) | w;
  endfunction
  function automatic logic [31:0] adr(int tg, int ix, int w);
    return {20'h0, tg[3:0], ix[3:0], w[1:0], 2'b00};
  endfunction
  function automatic logic [31:0] mrg(logic [31:0] o, logic [31:0] d, logic [3:0] be);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic cpu_op(input logic we, input logic [31:0] a, input logic [31:0] wd,
                        input logic [3:0] be, output logic [31:0] rd);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be;
    while (!cpu_ready) @(negedge clk);
    @(negedge clk);
    cpu_valid = 1'b0;
    while (!cpu_rvalid) @(negedge clk);
    rd = cpu_rdata;
  endtask

  task automatic do_flush(output int ready_hi, output int done_len);
    ready_hi = 0;
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    while (!flush_done) begin
      if (cpu_ready) ready_hi++;
      @(negedge clk);
    end
    @(negedge clk);
    done_len = flush_done ? 2 : 1;
  endtask

  task automatic t_reset();
    chk("R1 ready after reset", cpu_ready, 1);
    chk("R1 mem idle after reset", mem_valid, 0);
    chk("R1 done low after reset", flush_done, 0);
  endtask

  task automatic t_read();
    logic [31:0] d;
    int r0 = rd_cnt, w0 = wr_cnt;
    wt_mode = 1'b0;
    cpu_op(0, adr(1, 2, 3), 0, 0, d);
    chk("R1 R2 first read misses", rd_cnt - r0, 1);
    chk("R2 miss data", d, pat(8'h12, 3));
    cpu_op(0, adr(1, 2, 1), 0, 0, d);
    chk("R2 hit no memory read", rd_cnt - r0, 1);
    chk("R2 hit data", d, pat(8'h12, 1));
    cpu_op(0, adr(2, 2, 0), 0, 0, d);
    chk("R12 same index other tag misses", rd_cnt - r0, 2);
    chk("R12 conflict data", d, pat(8'h22, 0));
    chk("R5 clean victim no write", wr_cnt - w0, 0);
  endtask

  task automatic t_wb_hit_evict();
    logic [31:0] d, e;
    int w0;
    wt_mode = 1'b0;
    cpu_op(0, adr(3, 5, 0), 0, 0, d);
    w0 = wr_cnt;
    e = mrg(pat(8'h35, 2), 32'hDEAD_BEEF, 4'b0101);
    cpu_op(1, adr(3, 5, 2), 32'hDEAD_BEEF, 4'b0101, d);
    chk("R3 write-back hit no memory write", wr_cnt - w0, 0);
    cpu_op(0, adr(3, 5, 2), 0, 0, d);
    chk("R3 byte-enable merge", d, e);
    cpu_op(0, adr(4, 5, 0), 0, 0, d);
    chk("R4 dirty victim written", wr_cnt - w0, 1);
    chk("R4 victim address", wr_log[(wr_cnt - 1) % 64], adr(3, 5, 0));
    chk("R4 victim data", bmem[8'h35][2*32 +: 32], e);
    chk("R4 new line data", d, pat(8'h45, 0));
  endtask

  task automatic t_wt_hit();
    logic [31:0] d;
    int w0, r0;
    wt_mode = 1'b0;
    cpu_op(0, adr(5, 6, 0), 0, 0, d);
    wt_mode = 1'b1;
    w0 = wr_cnt; r0 = rd_cnt;
    cpu_op(1, adr(5, 6, 1), 32'h1122_3344, 4'b1111, d);
    chk("R6 write-through hit writes memory", wr_cnt - w0, 1);
    chk("R6 memory word", bmem[8'h56][1*32 +: 32], 32'h1122_3344);
    cpu_op(0, adr(5, 6, 1), 0, 0, d);
    chk("R6 cache updated, still hit", rd_cnt - r0, 0);
    chk("R6 cached word", d, 32'h1122_3344);
    cpu_op(0, adr(6, 6, 0), 0, 0, d);
    chk("R6 eviction after write-through is clean", wr_cnt - w0, 1);
  endtask

  task automatic t_wt_miss();
    logic [31:0] d, e;
    int w0 = wr_cnt, r0 = rd_cnt;
    wt_mode = 1'b1;
    e = mrg(pat(8'h77, 3), 32'hCAFE_F00D, 4'b1100);
    cpu_op(1, adr(7, 7, 3), 32'hCAFE_F00D, 4'b1100, d);
    chk("R7 write-through miss read", rd_cnt - r0, 1);
    chk("R7 write-through miss write", wr_cnt - w0, 1);
    chk("R7 merged memory word", bmem[8'h77][3*32 +: 32], e);
    cpu_op(0, adr(7, 7, 3), 0, 0, d);
    chk("R7 no allocation, read misses", rd_cnt - r0, 2);
    chk("R7 read data", d, e);
  endtask

  task automatic t_wb_miss_and_switch();
    logic [31:0] d, e;
    int w0 = wr_cnt, r0 = rd_cnt;
    wt_mode = 1'b0;
    e = mrg(pat(8'h88, 0), 32'hA5A5_A5A5, 4'b0011);
    cpu_op(1, adr(8, 8, 0), 32'hA5A5_A5A5, 4'b0011, d);
    chk("R8 write-back miss fetches", rd_cnt - r0, 1);
    chk("R8 write-back miss no write", wr_cnt - w0, 0);
    chk("R8 memory untouched", bmem[8'h88][31:0], pat(8'h88, 0));
    cpu_op(1, adr(9, 3, 1), 32'h0BAD_CAFE, 4'b1111, d);
    cpu_op(1, adr(1, 10, 2), 32'h7777_0000, 4'b1000, d);
    wt_mode = 1'b1;
    cpu_op(0, adr(8, 8, 0), 0, 0, d);
    chk("R8 R9 allocated line hits after switch", rd_cnt - r0, 3);
    chk("R8 merged word", d, e);
  endtask

  task automatic t_flush();
    int w0 = wr_cnt, rh, dl;
    do_flush(rh, dl);
    chk("R10 R9 dirty lines written", wr_cnt - w0, 3);
    chk("R10 order first", wr_log[w0 % 64], adr(9, 3, 0));
    chk("R10 order second", wr_log[(w0 + 1) % 64], adr(8, 8, 0));
    chk("R10 order third", wr_log[(w0 + 2) % 64], adr(1, 10, 0));
    chk("R9 dirty data reached memory", bmem[8'h88][31:0],
        mrg(pat(8'h88, 0), 32'hA5A5_A5A5, 4'b0011));
    chk("R10 flushed word", bmem[8'h93][1*32 +: 32], 32'h0BAD_CAFE);
    chk("R10 ready low during flush", rh, 0);
    chk("R10 done one cycle", dl, 1);
    w0 = wr_cnt;
    do_flush(rh, dl);
    chk("R10 dirty bits cleared", wr_cnt - w0, 0);
    chk("R10 empty flush done", dl, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++)
      for (int w = 0; w < 4; w++) bmem[i][w*32 +: 32] = pat(i, w);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read();
    t_wb_hit_evict();
    t_wt_hit();
    t_wt_miss();
    t_wb_miss_and_switch();
    t_flush();
    repeat (3) @(negedge clk);
    summary();
  end
endmodule